// File: doc/BRIEF.md
# Quad Wiper Register Command Executor

This block runs the register-level commands of a four-channel digital potentiometer. Each channel owns one 6-bit volatile wiper register and four 6-bit data registers. A serial front end hands the block a frame-start pulse and then a stream of bytes. The first byte after a frame start is an instruction. Depending on its opcode, the block then acts at once, waits for one data byte, or enters an open-ended stepping mode driven by per-clock step pulses. For every channel, the wiper register value is decoded into a one-hot select across 64 tap lines.

Read commands answer with a registered response byte. Commands that change a data register also raise a commit request to an external nonvolatile write sequencer. That sequencer reports back through a busy input. While it is busy, any further data-register change is refused. When reset is released, each wiper register is recalled from its channel's data register 0, whose reset contents are set by a parameter.

Top module: `wiperExec`

## Requirements
- R1: For each pot p, `tapSel[p*64 +: 64]` has exactly one bit set, at the index equal to that pot's wiper register value.
- R2: During reset every wiper register is 0. Data register 0 of pot p takes `INIT_DR0[p*6 +: 6]` and the other data registers take 0. On the first clock after reset is released, each wiper register is loaded from its pot's data register 0.
- R3: Bytes are ignored until `frameStart` is seen. The first byte after `frameStart` is the instruction: opcode in bits [7:4], register index in bits [3:2], pot index in bits [1:0]. A `frameStart` in the same cycle as a byte discards that byte.
- R4: Opcode 0xA (write wiper) loads the low six bits of the next byte into the selected pot's wiper register. The new tap select appears after that byte's clock.
- R5: Opcode 0x8 (read wiper) and opcode 0xB (read data register) pulse `rdValid` in the cycle after the instruction byte, with `rdData` = {2'b00, value}. When `rdValid` is low, `rdData` is 0.
- R6: Opcode 0x5 (read status) answers with `rdData` = {7'b0, commitBusy}, sampled with the instruction byte.
- R7: Opcode 0xD copies the indexed data register of the selected pot into its wiper register. Opcode 0x1 does the same for all four pots at once, using the same register index.
- R8: Opcode 0xC (write data register, low six bits of the next byte), opcode 0xE (wiper to data register) and opcode 0x6 (all wipers to their indexed data register) update the data registers. Each also pulses `commitReq` for one cycle with `commitPot` and `commitReg`. `commitAll` is 1 only for 0x6.
- R9: If `commitBusy` is high in the cycle that would change a data register, no data register changes and `commitReq` stays low.
- R10: After opcode 0x2, each `stepValid` pulse moves the selected wiper up by one when `stepUp` is 1 and down by one otherwise. The wiper saturates at 63 and at 0. Stepping continues until the next `frameStart`, and bytes are ignored meanwhile.
- R11: Unused opcodes, and any bytes after a command has completed, change nothing until the next `frameStart`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Start of a new command frame |
| byteValid | input | 1 | A byte is present on byteData |
| byteData | input | 8 | Instruction or data byte |
| stepValid | input | 1 | One step pulse in stepping mode |
| stepUp | input | 1 | Step direction, 1 moves toward tap 63 |
| commitBusy | input | 1 | Nonvolatile write sequencer is busy |
| tapSel | output | 256 | One-hot tap enables, 64 per pot |
| rdValid | output | 1 | Read response valid |
| rdData | output | 8 | Read response byte |
| commitReq | output | 1 | One-cycle commit request |
| commitAll | output | 1 | Commit applies to all pots |
| commitPot | output | 2 | Pot index of the commit |
| commitReg | output | 2 | Register index of the commit |

## Verification
The assertions assume that `byteValid` and `stepValid` are the only inputs that can move a wiper, that the front end never sends bytes faster than one per clock, and that `commitBusy` is a level driven by a well-behaved sequencer. The bench drives every input on the falling edge and holds it for exactly one clock. It raises `commitBusy` only as a plain level. In its random phase it mixes frame starts, legal and illegal instruction bytes, and step pulses, so every input stays within what the properties expect.

// File: rtl/wiperPkg.sv
package wiperPkg;
  localparam int POT_W    = 2;
  localparam int REG_W    = 2;
  localparam int WIPER_W  = 6;
  localparam int NUM_POTS = 1 << POT_W;
  localparam int NUM_REGS = 1 << REG_W;
  localparam int TAPS     = 1 << WIPER_W;

  typedef enum logic [3:0] {
    OP_GDR2W  = 4'h1,
    OP_STEP   = 4'h2,
    OP_STAT   = 4'h5,
    OP_GW2DR  = 4'h6,
    OP_RD_WCR = 4'h8,
    OP_WR_WCR = 4'hA,
    OP_RD_DR  = 4'hB,
    OP_WR_DR  = 4'hC,
    OP_DR2W   = 4'hD,
    OP_W2DR   = 4'hE
  } opT;

  typedef struct packed {
    logic               wcrLoad;
    logic               drLoad;
    logic               drToWcr;
    logic               wcrToDr;
    logic               allPots;
    logic               stepEn;
    logic               stepUp;
    logic               rdWcr;
    logic               rdDr;
    logic               rdStat;
    logic [POT_W-1:0]   potSel;
    logic [REG_W-1:0]   regSel;
    logic [WIPER_W-1:0] data;
  } strobeT;
endpackage

// File: rtl/wiperCtrl.sv
module wiperCtrl
  import wiperPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             stepValid,
  input  logic             stepUp,
  input  logic             commitBusy,
  output strobeT           strobe,
  output logic             commitReq,
  output logic             commitAll,
  output logic [POT_W-1:0] commitPot,
  output logic [REG_W-1:0] commitReg
);
  typedef enum logic [1:0] {S_WAIT, S_INSTR, S_DATA, S_STEP} stateT;

  stateT            state, stateNxt;
  logic             holdWcr, holdWcrNxt;
  logic [POT_W-1:0] potReg, potNxt;
  logic [REG_W-1:0] regReg, regNxt;
  opT               op;

  assign op = opT'(byteData[7:4]);

  always_comb begin
    strobe        = '0;
    strobe.potSel = potReg;
    strobe.regSel = regReg;
    strobe.data   = byteData[WIPER_W-1:0];
    stateNxt      = state;
    holdWcrNxt    = holdWcr;
    potNxt        = potReg;
    regNxt        = regReg;
    if (frameStart) begin
      stateNxt = S_INSTR;
    end else begin
      case (state)
        S_INSTR: if (byteValid) begin
          strobe.potSel = byteData[POT_W-1:0];
          strobe.regSel = byteData[POT_W +: REG_W];
          potNxt        = byteData[POT_W-1:0];
          regNxt        = byteData[POT_W +: REG_W];
          stateNxt      = S_WAIT;
          case (op)
            OP_RD_WCR: strobe.rdWcr = 1'b1;
            OP_RD_DR:  strobe.rdDr = 1'b1;
            OP_STAT:   strobe.rdStat = 1'b1;
            OP_WR_WCR: begin stateNxt = S_DATA; holdWcrNxt = 1'b1; end
            OP_WR_DR:  begin stateNxt = S_DATA; holdWcrNxt = 1'b0; end
            OP_DR2W:   strobe.drToWcr = 1'b1;
            OP_GDR2W:  begin strobe.drToWcr = 1'b1; strobe.allPots = 1'b1; end
            OP_W2DR:   strobe.wcrToDr = !commitBusy;
            OP_GW2DR:  begin strobe.wcrToDr = !commitBusy; strobe.allPots = 1'b1; end
            OP_STEP:   stateNxt = S_STEP;
            default:   stateNxt = S_WAIT;
          endcase
        end
        S_DATA: if (byteValid) begin
          stateNxt = S_WAIT;
          if (holdWcr) strobe.wcrLoad = 1'b1;
          else         strobe.drLoad  = !commitBusy;
        end
        S_STEP: if (stepValid) begin
          strobe.stepEn = 1'b1;
          strobe.stepUp = stepUp;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_WAIT;
      holdWcr   <= 1'b0;
      potReg    <= '0;
      regReg    <= '0;
      commitReq <= 1'b0;
      commitAll <= 1'b0;
      commitPot <= '0;
      commitReg <= '0;
    end else begin
      state     <= stateNxt;
      holdWcr   <= holdWcrNxt;
      potReg    <= potNxt;
      regReg    <= regNxt;
      commitReq <= strobe.drLoad | strobe.wcrToDr;
      commitAll <= strobe.wcrToDr & strobe.allPots;
      commitPot <= strobe.potSel;
      commitReg <= strobe.regSel;
    end
  end
endmodule

// File: rtl/wiperData.sv
module wiperData
  import wiperPkg::*;
#(
  parameter logic [NUM_POTS*WIPER_W-1:0] INIT_DR0 = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   strobe,
  input  logic                     commitBusy,
  output logic [NUM_POTS*TAPS-1:0] tapSel,
  output logic                     rdValid,
  output logic [7:0]               rdData
);
  localparam logic [WIPER_W-1:0] TOP_TAP = WIPER_W'(TAPS - 1);

  logic [WIPER_W-1:0] wcr [NUM_POTS];
  logic [WIPER_W-1:0] dr  [NUM_POTS][NUM_REGS];
  logic               recallPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recallPend <= 1'b1;
      for (int p = 0; p < NUM_POTS; p++) begin
        wcr[p] <= '0;
        for (int r = 0; r < NUM_REGS; r++)
          dr[p][r] <= (r == 0) ? INIT_DR0[p*WIPER_W +: WIPER_W] : '0;
      end
    end else begin
      recallPend <= 1'b0;
      for (int p = 0; p < NUM_POTS; p++) begin
        logic hitOne, hitAny;
        hitOne = (strobe.potSel == POT_W'(p));
        hitAny = hitOne | strobe.allPots;
        if (recallPend)
          wcr[p] <= dr[p][0];
        else if (strobe.wcrLoad && hitOne)
          wcr[p] <= strobe.data;
        else if (strobe.drToWcr && hitAny)
          wcr[p] <= dr[p][strobe.regSel];
        else if (strobe.stepEn && hitOne) begin
          if (strobe.stepUp && wcr[p] != TOP_TAP) wcr[p] <= wcr[p] + 1'b1;
          else if (!strobe.stepUp && wcr[p] != '0) wcr[p] <= wcr[p] - 1'b1;
        end
        if (strobe.drLoad && hitOne)
          dr[p][strobe.regSel] <= strobe.data;
        else if (strobe.wcrToDr && hitAny)
          dr[p][strobe.regSel] <= wcr[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rdWcr | strobe.rdDr | strobe.rdStat;
      if (strobe.rdWcr)
        rdData <= {{(8-WIPER_W){1'b0}}, wcr[strobe.potSel]};
      else if (strobe.rdDr)
        rdData <= {{(8-WIPER_W){1'b0}}, dr[strobe.potSel][strobe.regSel]};
      else if (strobe.rdStat)
        rdData <= {7'b0, commitBusy};
      else
        rdData <= '0;
    end
  end

  for (genvar g = 0; g < NUM_POTS; g++) begin : gTap
    assign tapSel[g*TAPS +: TAPS] = TAPS'(1) << wcr[g];
  end
endmodule

// File: rtl/wiperExec.sv
module wiperExec
  import wiperPkg::*;
#(
  parameter logic [NUM_POTS*WIPER_W-1:0] INIT_DR0 = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        stepValid,
  input  logic        stepUp,
  input  logic        commitBusy,
  output logic [NUM_POTS*TAPS-1:0] tapSel,
  output logic        rdValid,
  output logic [7:0]  rdData,
  output logic        commitReq,
  output logic        commitAll,
  output logic [POT_W-1:0] commitPot,
  output logic [REG_W-1:0] commitReg
);
  strobeT strobe;

  wiperCtrl uCtrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .byteData(byteData), .stepValid(stepValid), .stepUp(stepUp),
    .commitBusy(commitBusy), .strobe(strobe), .commitReq(commitReq),
    .commitAll(commitAll), .commitPot(commitPot), .commitReg(commitReg)
  );

  wiperData #(.INIT_DR0(INIT_DR0)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .commitBusy(commitBusy),
    .tapSel(tapSel), .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: rtl/wiperExecChk.sv
module wiperExecChk
  import wiperPkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic                     byteValid,
  input logic                     stepValid,
  input logic                     commitBusy,
  input logic [NUM_POTS*TAPS-1:0] tapSel,
  input logic                     rdValid,
  input logic                     commitReq
);
  for (genvar g = 0; g < NUM_POTS; g++) begin : gOne
    AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
      $countones(tapSel[g*TAPS +: TAPS]) == 1); // R1
  end

  AST_RD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(byteValid)); // R5

  AST_COMMIT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    commitReq |-> !$past(commitBusy)); // R9

  AST_TAP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !stepValid && $past(rstN)) |=> $stable(tapSel)); // R11
endmodule

bind wiperExec wiperExecChk uChk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .stepValid(stepValid),
  .commitBusy(commitBusy), .tapSel(tapSel), .rdValid(rdValid),
  .commitReq(commitReq)
);

// File: tb/sim_wiperExec.sv
module sim_wiperExec;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] INIT = {6'd0, 6'd63, 6'd5, 6'd32};

  logic clk = 1'b0, rstN = 1'b0;
  logic frameStart = 0, byteValid = 0, stepValid = 0, stepUp = 0, commitBusy = 0;
  logic [7:0] byteData = 0;
  logic [255:0] tapSel;
  logic rdValid, commitReq, commitAll;
  logic [7:0] rdData;
  logic [1:0] commitPot, commitReg;

  int checks = 0, errors = 0;
  bit finished = 0;

  int mW[4];
  int mD[4][4];
  int mode, mOp, mPot, mReg;
  bit mRecall;
  int eRdV, eRdD, eCq, eCall, eCpot, eCreg;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiperExec #(.INIT_DR0(INIT)) u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .byteData(byteData), .stepValid(stepValid), .stepUp(stepUp),
    .commitBusy(commitBusy), .tapSel(tapSel), .rdValid(rdValid),
    .rdData(rdData), .commitReq(commitReq), .commitAll(commitAll),
    .commitPot(commitPot), .commitReg(commitReg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tapIdx(input int p);
    int idx = -1;
    for (int i = 0; i < 64; i++) if (tapSel[p*64+i]) idx = i;
    return idx;
  endfunction

  task automatic compareAll();
    for (int p = 0; p < 4; p++)
      chk(tapSel[p*64 +: 64] === (64'd1 << mW[p]), "R1 tap", tapIdx(p), mW[p]);
    chk(rdValid === eRdV[0], "R5 rdValid", int'(rdValid), eRdV);
    chk(rdData === 8'(eRdD), "R5 rdData", int'(rdData), eRdD);
    chk(commitReq === eCq[0], "R8 commitReq", int'(commitReq), eCq);
    if (eCq != 0) begin
      chk(commitAll === eCall[0], "R8 commitAll", int'(commitAll), eCall);
      chk(commitPot === 2'(eCpot), "R8 commitPot", int'(commitPot), eCpot);
      chk(commitReg === 2'(eCreg), "R8 commitReg", int'(commitReg), eCreg);
    end
  endtask

  task automatic model(input bit fs, bv, input int bd, input bit sv, su, busy);
    int op, r, p;
    eRdV = 0; eRdD = 0; eCq = 0;
    if (mRecall) begin
      for (int k = 0; k < 4; k++) mW[k] = mD[k][0];
      mRecall = 0;
    end
    op = (bd >> 4) & 15; r = (bd >> 2) & 3; p = bd & 3;
    if (fs) mode = 1;
    else if (mode == 1 && bv) begin
      mode = 0; mPot = p; mReg = r; mOp = op;
      case (op)
        8:  begin eRdV = 1; eRdD = mW[p]; end
        11: begin eRdV = 1; eRdD = mD[p][r]; end
        5:  begin eRdV = 1; eRdD = busy; end
        10, 12: mode = 2;
        13: mW[p] = mD[p][r];
        1:  for (int k = 0; k < 4; k++) mW[k] = mD[k][r];
        14: if (!busy) begin
              mD[p][r] = mW[p]; eCq = 1; eCall = 0; eCpot = p; eCreg = r;
            end
        6:  if (!busy) begin
              for (int k = 0; k < 4; k++) mD[k][r] = mW[k];
              eCq = 1; eCall = 1; eCpot = p; eCreg = r;
            end
        2:  mode = 3;
        default: ;
      endcase
    end else if (mode == 2 && bv) begin
      mode = 0;
      if (mOp == 10) mW[mPot] = bd & 63;
      else if (!busy) begin
        mD[mPot][mReg] = bd & 63; eCq = 1; eCall = 0; eCpot = mPot; eCreg = mReg;
      end
    end else if (mode == 3 && sv) begin
      if (su && mW[mPot] < 63) mW[mPot]++;
      else if (!su && mW[mPot] > 0) mW[mPot]--;
    end
  endtask

  task automatic cyc(input bit fs, bv, input int bd, input bit sv, su);
    frameStart = fs; byteValid = bv; byteData = 8'(bd); stepValid = sv; stepUp = su;
    model(fs, bv, bd, sv, su, commitBusy);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic frame();           cyc(1, 0, 0, 0, 0); endtask
  task automatic sendByte(input int b); cyc(0, 1, b, 0, 0); endtask
  task automatic step(input bit up); cyc(0, 0, 0, 1, up); endtask
  task automatic idle();            cyc(0, 0, 0, 0, 0); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      mW[p] = 0;
      for (int r = 0; r < 4; r++) mD[p][r] = (r == 0) ? int'(INIT[p*6 +: 6]) : 0;
    end
    mode = 0; mRecall = 1; eRdV = 0; eRdD = 0; eCq = 0; eCall = 0; eCpot = 0; eCreg = 0;
    mOp = 0; mPot = 0; mReg = 0;
    repeat (3) @(negedge clk);
    // R2: reset state before recall
    for (int p = 0; p < 4; p++) chk(tapIdx(p) == 0, "R2 reset tap", tapIdx(p), 0);
    chk(rdValid == 0 && commitReq == 0, "R2 reset outputs", int'(rdValid), 0);
    rstN = 1;
    idle();
    chk(tapIdx(0) == 32, "R2 recall pot0", tapIdx(0), 32);
    chk(tapIdx(1) == 5, "R2 recall pot1", tapIdx(1), 5);
    chk(tapIdx(2) == 63, "R2 recall pot2", tapIdx(2), 63);
    chk(tapIdx(3) == 0, "R2 recall pot3", tapIdx(3), 0);

    // R3: bytes before a frame start are ignored
    sendByte(8'hA1); sendByte(8'h11);
    chk(tapIdx(1) == 5, "R3 no frame", tapIdx(1), 5);
    // R3: byte in the same cycle as frameStart is dropped
    cyc(1, 1, 8'hA1, 0, 0); sendByte(8'h81);
    chk(rdValid && rdData == 5, "R3 same-cycle byte", int'(rdData), 5);

    // R4: write wiper pot1 with 0xD5 -> 21
    frame(); sendByte(8'hA1); sendByte(8'hD5);
    chk(tapIdx(1) == 21, "R4 write wiper", tapIdx(1), 21);
    sendByte(8'h3F);
    chk(tapIdx(1) == 21, "R11 trailing byte", tapIdx(1), 21);

    // R5: reads
    frame(); sendByte(8'h81);
    chk(rdValid && rdData == 21, "R5 read wiper", int'(rdData), 21);
    idle();
    chk(!rdValid && rdData == 0, "R5 idle rdData", int'(rdData), 0);
    frame(); sendByte(8'hB2);
    chk(rdValid && rdData == 63, "R5 read dr", int'(rdData), 63);

    // R8: write data register pot0 reg2 with 0xE7 -> 39
    frame(); sendByte(8'hC8); sendByte(8'hE7);
    chk(commitReq && commitPot == 0 && commitReg == 2 && !commitAll, "R8 commit single",
        int'(commitReg), 2);
    frame(); sendByte(8'hB8);
    chk(rdData == 39, "R8 readback", int'(rdData), 39);

    // R7: single and global transfers to the wiper
    frame(); sendByte(8'hD8);
    chk(tapIdx(0) == 39, "R7 single xfer", tapIdx(0), 39);
    frame(); sendByte(8'h10);
    chk(tapIdx(0) == 32 && tapIdx(1) == 5, "R7 global xfer", tapIdx(0), 32);

    // R8: wiper to data register, single and global
    frame(); sendByte(8'hA1); sendByte(8'h0C);
    frame(); sendByte(8'hE5);
    chk(commitReq && !commitAll, "R8 wcr to dr", int'(commitReq), 1);
    frame(); sendByte(8'hB5);
    chk(rdData == 12, "R8 wcr to dr value", int'(rdData), 12);
    frame(); sendByte(8'h6C);
    chk(commitReq && commitAll && commitReg == 3, "R8 global commit", int'(commitAll), 1);
    frame(); sendByte(8'hBE);
    chk(rdData == 63, "R8 global value pot2", int'(rdData), 63);

    // R9 / R6: busy rejection and status
    commitBusy = 1;
    frame(); sendByte(8'hC7); sendByte(8'h09);
    chk(!commitReq, "R9 busy no commit", int'(commitReq), 0);
    frame(); sendByte(8'hB7);
    chk(rdData == 0, "R9 busy dr unchanged", int'(rdData), 0);
    frame(); sendByte(8'h50);
    chk(rdData == 1, "R6 status busy", int'(rdData), 1);
    commitBusy = 0;
    frame(); sendByte(8'h50);
    chk(rdValid && rdData == 0, "R6 status idle", int'(rdData), 0);

    // R10: stepping with saturation
    frame(); sendByte(8'h22);
    step(1); step(1);
    chk(tapIdx(2) == 63, "R10 top saturate", tapIdx(2), 63);
    step(0); step(0); sendByte(8'hA2); step(0);
    chk(tapIdx(2) == 60, "R10 step down", tapIdx(2), 60);
    frame(); sendByte(8'h23);
    step(0);
    chk(tapIdx(3) == 0, "R10 bottom saturate", tapIdx(3), 0);
    step(1);
    chk(tapIdx(3) == 1, "R10 step up", tapIdx(3), 1);
    frame(); step(1);
    chk(tapIdx(3) == 1, "R10 ends on frame", tapIdx(3), 1);

    // R11: unused opcode
    frame(); sendByte(8'hF0); sendByte(8'h81);
    chk(!rdValid && tapIdx(0) == 32, "R11 unused opcode", int'(rdValid), 0);

    // random mix, checked every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      int sel, b;
      if ($urandom_range(0, 9) == 0) commitBusy = ~commitBusy;
      sel = $urandom_range(0, 9);
      if ($urandom_range(0, 1) == 0) b = $urandom_range(0, 255);
      else begin
        int ops[10] = '{1, 2, 5, 6, 8, 10, 11, 12, 13, 14};
        b = (ops[$urandom_range(0, 9)] << 4) | $urandom_range(0, 15);
      end
      if (sel == 0) frame();
      else if (sel < 5) sendByte(b);
      else if (sel < 8) step($urandom_range(0, 1) == 1);
      else idle();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule